// File: doc/BRIEF.md
# Checksum-Guarded Linear Datapath Checker

This block watches a linear unit that maps each input vector to a scalar through a fixed-coefficient dot product, the same shape as one row of a matrix-vector product. It never repeats the full per-vector work. Instead it relies on linearity: the weighted sum of a sum of vectors equals the sum of the individual weighted sums.

The block has two accumulators. One sums, lane by lane, every input vector of a batch of `K`. The other sums the `K` scalar results that the unit under check returns. When both streams have delivered `K` items, a second copy of the dot product is applied to the lane-wise input sum and the result is compared with the result sum. A mismatch shows that at least one result was corrupted, for example by a transient upset. The check is issued as each batch closes.

The two streams each have their own valid/ready handshake. They may arrive interleaved, one wholly ahead of the other, or with idle gaps. A fault-injection input inverts one chosen bit of a result as that result is accepted, so that detection can be exercised.

Top module: `lin_sum_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `done` and `flag_err` are 0 and both `vec_rdy` and `res_rdy` are 1.
- R2: An input vector is taken only in a cycle where `vec_vld` and `vec_rdy` are both 1. Once `K` vectors of the current batch have been taken, `vec_rdy` stays 0, and any vector offered then has no effect on the check, until the batch closes.
- R3: A result is taken only in a cycle where `res_vld` and `res_rdy` are both 1. Once `K` results of the current batch have been taken, `res_rdy` stays 0, and any result offered then has no effect on the check, until the batch closes.
- R4: A batch closes at the clock edge where the later of the `K`-th vector and the `K`-th result is taken. `done` is 1 for exactly the following cycle, and both ready outputs are 1 again in that cycle.
- R5: When every result equals the dot product of its vector, `flag_err` is 0 in the `done` cycle.
- R6: When the sum of the accepted results differs from the dot product of the lane-wise input sum, `flag_err` is 1 in the `done` cycle. Lane `i` of `vec_data` occupies bits `[i*W +: W]`. Both lanes and coefficients are two's complement. The default coefficients for lanes 0..3 are 3, -2, 5, 7, packed four bits per lane with lane 0 in the least significant bits (`16'h75E3`).
- R7: When `inj_en` is 1 in a cycle where a result is taken, bit `inj_sel` of that result is inverted before it is summed. `inj_en` in a cycle where no result is taken has no effect.
- R8: The outcome does not depend on the relative timing of the two streams: interleaved, all vectors first, all results first, or with idle gaps.
- R9: `flag_err` is 0 in every cycle where `done` is 0.
- R10: Sums are wide enough that batches made entirely of the most negative or the most positive lane value raise no false alarm, and a flip of the result sign bit is still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_vld | input | 1 | Input vector offered |
| vec_rdy | output | 1 | Checker can take an input vector |
| vec_data | input | N*W | Input vector, lane i at bits [i*W +: W] |
| res_vld | input | 1 | Result offered by the unit under check |
| res_rdy | output | 1 | Checker can take a result |
| res_data | input | RW | Result, two's complement |
| inj_en | input | 1 | Invert one bit of the result taken this cycle |
| inj_sel | input | BW | Index of the bit that `inj_en` inverts |
| done | output | 1 | One-cycle pulse when a batch closes |
| flag_err | output | 1 | Checksum mismatch, valid while `done` is 1 |

## Verification
The embedded properties assume that reset is held low across at least one rising edge before any traffic, and that `vec_data` and `res_data` carry known values whenever the matching valid is high. They do not assume that a valid stays high until it is taken. The stimulus therefore drops and raises valid freely in gap mode and offers extra items while ready is low. All lane values are produced by a bounded formula that fits `W` bits, and every result fits `RW` bits. At most one bit of one result is inverted per batch, so no pair of corruptions can cancel. Expected outcomes come from a separate integer model of the dot product.

// File: rtl/lin_sum_guard.sv
module lin_sum_guard #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int K = 8,
  parameter int CW = 4,
  parameter logic [N*CW-1:0] COEFS = 16'h75E3,
  parameter int RW = W + CW + $clog2(N) + 1,
  parameter int BW = (RW > 1) ? $clog2(RW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_vld,
  output logic          vec_rdy,
  input  logic [N*W-1:0] vec_data,
  input  logic          res_vld,
  output logic          res_rdy,
  input  logic [RW-1:0] res_data,
  input  logic          inj_en,
  input  logic [BW-1:0] inj_sel,
  output logic          done,
  output logic          flag_err
);
  localparam int KW  = $clog2(K + 1);
  localparam int SW  = W + $clog2(K) + 1;
  localparam int CKW = RW + $clog2(K) + 2;

  logic [KW-1:0] vec_cnt, res_cnt, vec_cnt_nx, res_cnt_nx;
  logic signed [SW-1:0]  lane_sum [N];
  logic signed [SW-1:0]  lane_sum_nx [N];
  logic signed [CKW-1:0] res_sum, res_sum_nx, chk_dot;
  logic [RW-1:0] res_eff;
  logic vec_take, res_take, close_now;

  assign vec_rdy  = (vec_cnt != KW'(K));
  assign res_rdy  = (res_cnt != KW'(K));
  assign vec_take = vec_vld && vec_rdy;
  assign res_take = res_vld && res_rdy;

  assign res_eff    = res_data ^ (inj_en ? (RW'(1) << inj_sel) : RW'(0));
  assign res_sum_nx = res_take ? res_sum + CKW'($signed(res_eff)) : res_sum;
  assign vec_cnt_nx = vec_take ? vec_cnt + 1'b1 : vec_cnt;
  assign res_cnt_nx = res_take ? res_cnt + 1'b1 : res_cnt;
  assign close_now  = (vec_cnt_nx == KW'(K)) && (res_cnt_nx == KW'(K));

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane_sum_nx[g] = vec_take ? lane_sum[g] + SW'($signed(vec_data[g*W +: W]))
                                     : lane_sum[g];
  end

  always_comb begin
    chk_dot = '0;
    for (int i = 0; i < N; i++)
      chk_dot = chk_dot + CKW'(lane_sum_nx[i]) * CKW'($signed(COEFS[i*CW +: CW]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_cnt  <= '0;
      res_cnt  <= '0;
      res_sum  <= '0;
      done     <= 1'b0;
      flag_err <= 1'b0;
      for (int i = 0; i < N; i++) lane_sum[i] <= '0;
    end else if (close_now) begin
      vec_cnt  <= '0;
      res_cnt  <= '0;
      res_sum  <= '0;
      done     <= 1'b1;
      flag_err <= (chk_dot != res_sum_nx);
      for (int i = 0; i < N; i++) lane_sum[i] <= '0;
    end else begin
      vec_cnt  <= vec_cnt_nx;
      res_cnt  <= res_cnt_nx;
      res_sum  <= res_sum_nx;
      done     <= 1'b0;
      flag_err <= 1'b0;
      for (int i = 0; i < N; i++) lane_sum[i] <= lane_sum_nx[i];
    end
  end

  p_vec_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && !close_now) |=> (vec_cnt == $past(vec_cnt) + 1'b1));
  p_vec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_take && !close_now) |=> $stable(vec_cnt));
  p_res_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_take && !close_now) |=> (res_cnt == $past(res_cnt) + 1'b1));
  p_res_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_take && !close_now) |=> $stable(res_cnt));
  p_close_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    close_now |=> done);
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vec_rdy && res_rdy));
  p_err_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_err |-> done);
endmodule

// File: tb/lin_sum_guard_tb.sv
module lin_sum_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, W = 8, K = 8, RW = 15, BW = 4;

  typedef struct packed {
    logic [7:0] seed;
    logic [1:0] mode;
    logic [3:0] inj_idx;
    logic [3:0] inj_bit;
    logic       exp_err;
  } row_t;

  localparam row_t TAB [8] = '{
    '{8'd1, 2'd0, 4'd15, 4'd0,  1'b0},
    '{8'd2, 2'd1, 4'd15, 4'd0,  1'b0},
    '{8'd3, 2'd2, 4'd15, 4'd0,  1'b0},
    '{8'd4, 2'd3, 4'd15, 4'd0,  1'b0},
    '{8'd5, 2'd0, 4'd0,  4'd0,  1'b1},
    '{8'd6, 2'd1, 4'd7,  4'd14, 1'b1},
    '{8'd7, 2'd2, 4'd3,  4'd5,  1'b1},
    '{8'd8, 2'd3, 4'd5,  4'd9,  1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic vec_vld = 0, res_vld = 0, inj_en = 0;
  logic [N*W-1:0] vec_data = '0;
  logic [RW-1:0] res_data = '0;
  logic [BW-1:0] inj_sel = '0;
  logic vec_rdy, res_rdy, done, flag_err;

  int n_chk = 0, n_bad = 0, done_cnt = 0, stray_err = 0, pat_kind = 0;
  bit idle_inj = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_sum_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .vec_vld(vec_vld), .vec_rdy(vec_rdy), .vec_data(vec_data),
    .res_vld(res_vld), .res_rdy(res_rdy), .res_data(res_data),
    .inj_en(inj_en), .inj_sel(inj_sel),
    .done(done), .flag_err(flag_err)
  );

  always @(negedge clk) begin
    if (rst_n && done) done_cnt++;
    if (rst_n && flag_err && !done) stray_err++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int elem(int s, int j, int i);
    if (pat_kind == 1) return -128;
    if (pat_kind == 2) return 127;
    return ((s*37 + j*11 + i*23 + s*j*5) % 256) - 128;
  endfunction

  function automatic int fdot(int s, int j);
    return 3*elem(s,j,0) - 2*elem(s,j,1) + 5*elem(s,j,2) + 7*elem(s,j,3);
  endfunction

  task automatic send_vec(int s, int mode);
    for (int j = 0; j < K; j++) begin
      bit took = 0;
      int tick = 0;
      while (!took) begin
        bit rdy;
        @(negedge clk);
        if (mode == 3 && (tick % 2 == 0)) vec_vld = 0;
        else begin
          vec_vld = 1;
          for (int i = 0; i < N; i++) vec_data[i*W +: W] = 8'(elem(s, j, i));
        end
        rdy = vec_rdy;
        tick++;
        @(posedge clk);
        took = vec_vld && rdy;
      end
    end
    #1 vec_vld = 0;
  endtask

  task automatic send_res(int s, int mode, int inj_idx, int inj_bit);
    for (int j = 0; j < K; j++) begin
      bit took = 0;
      int tick = 0;
      while (!took) begin
        bit rdy;
        @(negedge clk);
        if (mode == 3 && (tick % 2 == 1)) begin
          res_vld = 0;
          inj_en  = idle_inj;
          inj_sel = 4'd3;
        end else begin
          res_vld  = 1;
          res_data = RW'(fdot(s, j));
          inj_en   = (j == inj_idx);
          inj_sel  = BW'(inj_bit);
        end
        rdy = res_rdy;
        tick++;
        @(posedge clk);
        took = res_vld && rdy;
      end
    end
    #1;
    res_vld = 0;
    inj_en  = 0;
  endtask

  task automatic run_batch(string tag, int s, int mode, int inj_idx, int inj_bit, int exp_err);
    int d0 = done_cnt;
    if (mode == 1) begin
      send_vec(s, mode);
      @(negedge clk);
      chk({tag, " R2 vec_rdy low when full"}, int'(vec_rdy), 0);
      vec_vld = 1;
      vec_data = {N{8'h7F}};
      @(negedge clk);
      @(negedge clk);
      vec_vld = 0;
      chk({tag, " R2 no close on vectors alone"}, done_cnt - d0, 0);
      send_res(s, mode, inj_idx, inj_bit);
    end else if (mode == 2) begin
      send_res(s, mode, inj_idx, inj_bit);
      @(negedge clk);
      chk({tag, " R3 res_rdy low when full"}, int'(res_rdy), 0);
      res_vld = 1;
      res_data = 15'h1234;
      @(negedge clk);
      @(negedge clk);
      res_vld = 0;
      chk({tag, " R3 no close on results alone"}, done_cnt - d0, 0);
      send_vec(s, mode);
    end else begin
      fork
        send_vec(s, mode);
        send_res(s, mode, inj_idx, inj_bit);
      join
    end
    @(negedge clk);
    chk({tag, " R4 done after last take"}, int'(done), 1);
    chk({tag, exp_err ? " R6 flag_err" : " R5 flag_err"}, int'(flag_err), exp_err);
    chk({tag, " R4 ready restored"}, int'(vec_rdy && res_rdy), 1);
    @(negedge clk);
    chk({tag, " R4 done one cycle"}, int'(done), 0);
    chk({tag, " R9 flag_err low"}, int'(flag_err), 0);
    chk({tag, " R4 one pulse per batch"}, done_cnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 flag_err in reset", int'(flag_err), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 vec_rdy after reset", int'(vec_rdy), 1);
    chk("R1 res_rdy after reset", int'(res_rdy), 1);
    chk("R1 done after reset", int'(done), 0);

    for (int r = 0; r < 8; r++)
      run_batch($sformatf("R8 row%0d", r), int'(TAB[r].seed), int'(TAB[r].mode),
                int'(TAB[r].inj_idx), int'(TAB[r].inj_bit), int'(TAB[r].exp_err));

    idle_inj = 1;
    run_batch("R7 idle inject", 11, 3, 15, 0, 0);
    idle_inj = 0;
    run_batch("R7 inject msb", 12, 0, 6, 14, 1);

    pat_kind = 1;
    run_batch("R10 all min", 0, 0, 15, 0, 0);
    pat_kind = 2;
    run_batch("R10 all max", 0, 1, 15, 0, 0);
    run_batch("R10 max sign flip", 0, 2, 2, 14, 1);
    pat_kind = 0;

    chk("R9 no flag_err outside done", stray_err, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule